// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns an asynchronous serial line into a stream of received characters. A 16x oversampling tick paces it. A falling edge on the line starts a frame, and the start bit is confirmed half a bit later. The receiver then samples each data bit, the optional parity bit and one stop bit at the middle of its bit period. Word length, parity enable, even or odd parity and stick parity are taken from control inputs at run time. The settings are captured when a start bit is confirmed, so a change mid-frame does not disturb the frame in flight.

Each finished frame produces one character: the data byte plus three flags for a bad stop bit, a bad parity bit and a break condition. Characters go into a store. With the buffering control clear, the store holds a single character. With it set, the store is a first-in first-out queue of configurable depth. The consumer takes the head with a valid/ready pair. A character that finds no room is lost, and a sticky overrun output records the loss until reset.

Top module: `serial_rx_frame`

## Requirements
- R1: `cfg_len` selects the word length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives least significant bit first. In `chr_data`, bit 0 is the first data bit received, and bits above the word length read 0.
- R2: With `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_even` = 1, `chr_perr` is set when the number of ones across the data and parity bits is odd. With `cfg_par_even` = 0, it is set when that number is even. With `cfg_par_en` = 0, no parity bit is expected and `chr_perr` is 0.
- R3: With `cfg_par_en` = 1 and `cfg_par_stick` = 1, the expected parity bit is the inverse of `cfg_par_even`, whatever the data. `chr_perr` is set when the received parity bit differs from it.
- R4: A falling edge on `rx_line` starts a frame only if the line still reads low on the 8th tick afterwards. Otherwise the receiver returns to idle and produces no character.
- R5: After the start check, every following bit is sampled on every 16th tick. A stop bit sampled low sets `chr_ferr` for that character.
- R6: A frame whose data bits, parity bit (when enabled) and stop bit are all low sets `chr_brk`, together with `chr_ferr`. After a break, a new frame needs the line to rise and fall again.
- R7: Only the first stop bit is checked. A new start bit may begin right after the first stop bit.
- R8: With `cfg_buf_en` = 0, the store holds one character. With `cfg_buf_en` = 1, it holds up to DEPTH characters in arrival order. The head is presented while `chr_valid` is 1 and is removed by `chr_ready` = 1 on a clock edge.
- R9: A character that completes with no room in the store is dropped, and `rx_overrun` becomes 1 and stays 1 until reset. A removal on the same edge as a completion frees room for the new character.
- R10: After reset, `chr_valid` and `rx_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Word length select (0..3 for 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_par_stick | input | 1 | Fixed parity bit equal to the inverse of cfg_par_even |
| cfg_buf_en | input | 1 | Queue of DEPTH characters when 1, single character when 0 |
| chr_ready | input | 1 | Consumer removes the head character |
| chr_valid | output | 1 | A character is available |
| chr_data | output | 8 | Head character data |
| chr_ferr | output | 1 | Head character had a low stop bit |
| chr_perr | output | 1 | Head character had a wrong parity bit |
| chr_brk | output | 1 | Head character was a break |
| rx_overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
Two events can land on the same clock edge: a frame completing into a full store, and the consumer removing the head. The bench provokes this in single-character mode. With one character held, it raises `chr_ready` in exactly the cycle of the tick that samples the next frame's stop bit. It then expects the old character to be removed, the new one to be held, and `rx_overrun` to stay 0. A later frame with no removal must then set the overrun flag and leave the held character intact.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       ferr;
    logic       perr;
    logic       brk;
  } rx_char_t;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } rx_cfg_t;

  // number of data bits for a length code
  function automatic logic [3:0] word_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // data bits plus optional parity bit
  function automatic logic [3:0] frame_bits(input logic [1:0] len, input logic par_en);
    return word_bits(len) + {3'b000, par_en};
  endfunction

  function automatic logic [7:0] word_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // parity bit the receiver expects for a given word
  function automatic logic want_parity(input logic [7:0] data, input logic even,
                                       input logic stick);
    if (stick) return ~even;
    return even ? ^data : ~^data;
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  output logic rx_s,
  output logic rx_fall
);
  // pipe[STAGES-1] is the synchronized line, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], rx_pin};
  end

  assign rx_s    = pipe[STAGES-1];
  assign rx_fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    rx_s,
  input  logic    rx_fall,
  input  rx_cfg_t cfg_in,
  output logic    frame_done,
  output logic    stop_bit,
  output logic [8:0] frame_raw,
  output rx_cfg_t frame_cfg
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t        state;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [8:0] raw;
  rx_cfg_t    cfg_q;

  // named events for the checks
  logic mid_hit, bit_hit, start_ok, start_glitch, last_bit;
  assign mid_hit      = tick && (cnt == MID);
  assign bit_hit      = tick && (cnt == LAST);
  assign start_ok     = (state == S_START) && mid_hit && !rx_s;
  assign start_glitch = (state == S_START) && mid_hit && rx_s;
  assign last_bit     = (idx == frame_bits(cfg_q.len, cfg_q.par_en) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      raw   <= '0;
      cfg_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (rx_fall) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (start_ok) begin
            state <= S_BITS;
            cnt   <= '0;
            idx   <= '0;
            raw   <= '0;
            cfg_q <= cfg_in;
          end else if (start_glitch) begin
            state <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BITS: begin
          if (bit_hit) begin
            raw[idx] <= rx_s;
            cnt      <= '0;
            if (last_bit) state <= S_STOP;
            else          idx   <= idx + 4'd1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (bit_hit) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign frame_done = (state == S_STOP) && bit_hit;
  assign stop_bit   = rx_s;
  assign frame_raw  = raw;
  assign frame_cfg  = cfg_q;

  // R4: a start bit that reads high at mid-bit sends the receiver back to idle
  a_r4_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |=> (state == S_IDLE));

  // R5: completions are at least one bit period apart
  a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/serial_rx_judge.sv
module serial_rx_judge
  import serial_rx_pkg::*;
(
  input  logic [8:0] raw,
  input  rx_cfg_t    cfg,
  input  logic       stop_bit,
  output rx_char_t   chr
);
  logic [7:0] data;
  logic       pbit;
  logic       par_bad;

  assign data    = raw[7:0] & word_mask(cfg.len);
  assign pbit    = raw[word_bits(cfg.len)];
  assign par_bad = pbit != want_parity(data, cfg.par_even, cfg.par_stick);

  always_comb begin
    chr.data = data;
    chr.ferr = ~stop_bit;
    chr.perr = cfg.par_en & par_bad;
    chr.brk  = (data == 8'h00) && !stop_bit && (!cfg.par_en || !pbit);
  end

endmodule

// File: rtl/serial_rx_store.sv
module serial_rx_store
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     buf_en,
  input  logic     push_req,
  input  rx_char_t push_char,
  input  logic     pop_req,
  output logic     head_valid,
  output rx_char_t head_char,
  output logic     overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  logic [CW-1:0] cap, avail;
  logic          pop, push, drop, room;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap   = buf_en ? CW'(DEPTH) : CW'(1);
  assign pop   = pop_req && (count != '0);
  assign avail = count - CW'(pop);
  assign room  = avail < cap;
  assign push  = push_req && room;
  assign drop  = push_req && !room;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      count <= count + CW'(push) - CW'(pop);
      if (drop) overrun <= 1'b1;
    end
  end

  assign head_valid = count != '0;
  assign head_char  = mem[rptr];

  // R8: occupancy never exceeds the queue depth
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: a dropped character leaves occupancy unchanged
  a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> (count == $past(count)));

  // R9: completing into a full store raises overrun
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && count >= cap && !pop_req) |=> overrun);

  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_buf_en,
  input  logic       chr_ready,
  output logic       chr_valid,
  output logic [7:0] chr_data,
  output logic       chr_ferr,
  output logic       chr_perr,
  output logic       chr_brk,
  output logic       rx_overrun
);
  logic     rx_s, rx_fall;
  logic     frame_done, stop_bit;
  logic [8:0] frame_raw;
  rx_cfg_t  cfg_live, frame_cfg;
  rx_char_t new_char, head_char;

  assign cfg_live = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                      par_stick: cfg_par_stick};

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_line), .rx_s(rx_s), .rx_fall(rx_fall)
  );

  serial_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .rx_fall(rx_fall),
    .cfg_in(cfg_live), .frame_done(frame_done), .stop_bit(stop_bit),
    .frame_raw(frame_raw), .frame_cfg(frame_cfg)
  );

  serial_rx_judge u_judge (
    .raw(frame_raw), .cfg(frame_cfg), .stop_bit(stop_bit), .chr(new_char)
  );

  serial_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_en(cfg_buf_en), .push_req(frame_done),
    .push_char(new_char), .pop_req(chr_ready), .head_valid(chr_valid),
    .head_char(head_char), .overrun(rx_overrun)
  );

  assign chr_data = head_char.data;
  assign chr_ferr = head_char.ferr;
  assign chr_perr = head_char.perr;
  assign chr_brk  = head_char.brk;

  // R6: a break character always carries a framing error
  a_r6_brk_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && chr_brk) |-> chr_ferr);

  // R2: a parity error is only reported for frames that carried parity
  a_r2_perr_needs_pen: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_cfg.par_en) |-> !new_char.perr);

endmodule

// File: tb/serial_rx_frame_bench.sv
module serial_rx_frame_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, os_tick, rx_line, chr_ready;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_even, cfg_par_stick, cfg_buf_en;
  logic       chr_valid, chr_ferr, chr_perr, chr_brk, rx_overrun;
  logic [7:0] chr_data;

  localparam int BENCH_DEPTH = 4;

  serial_rx_frame #(.DEPTH(BENCH_DEPTH)) u_serial_rx_frame (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_buf_en(cfg_buf_en), .chr_ready(chr_ready),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_ferr(chr_ferr),
    .chr_perr(chr_perr), .chr_brk(chr_brk), .rx_overrun(rx_overrun)
  );

  int checks = 0;
  int errors = 0;
  logic [10:0] expq[$];   // {data, ferr, perr, brk}
  logic exp_ovr = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic bench_parity(input logic [7:0] d, input int nb,
                                        input logic even, input logic stick);
    int ones = 0;
    if (stick) return !even;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    return even ? ones[0] : !ones[0];
  endfunction

  task automatic check_head(input string req);
    logic [10:0] e;
    chk({req, " valid"}, int'(chr_valid), 1);
    if (expq.size() == 0) return;
    e = expq[0];
    chk({req, " data"}, int'(chr_data), int'(e[10:3]));
    chk({req, " ferr"}, int'(chr_ferr), int'(e[2]));
    chk({req, " perr"}, int'(chr_perr), int'(e[1]));
    chk({req, " brk"},  int'(chr_brk),  int'(e[0]));
  endtask

  task automatic pop_one(input string req);
    check_head(req);
    chr_ready = 1'b1;
    @(negedge clk);
    chr_ready = 1'b0;
    if (expq.size() != 0) void'(expq.pop_front());
  endtask

  task automatic one_tick(input logic rdy);
    os_tick   = 1'b1;
    chr_ready = rdy;
    @(negedge clk);
    os_tick   = 1'b0;
    chr_ready = 1'b0;
    @(negedge clk);
  endtask

  // one frame with a single stop bit; optionally remove the head on the stop sampling tick
  task automatic send(input logic [7:0] d, input logic flip, input logic stopv,
                      input logic pop_stop, input string req);
    int nb = 5 + int'(cfg_len);
    logic [7:0] dm = d & (8'hFF >> (3 - int'(cfg_len)));
    logic pb = bench_parity(dm, nb, cfg_par_even, cfg_par_stick) ^ flip;
    logic [11:0] bits = '0;
    int total = 0;
    int cap;
    logic brk;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[1 + i] = dm[i];
    total = 1 + nb;
    if (cfg_par_en) begin
      bits[total] = pb;
      total++;
    end
    bits[total] = stopv;
    total++;
    for (int b = 0; b < total; b++) begin
      rx_line = bits[b];
      if (b == 0) repeat (4) @(negedge clk);
      for (int t = 1; t <= 16; t++) begin
        logic rdy = pop_stop && (b == total - 1) && (t == 8);
        if (rdy) begin
          check_head({req, " head before same-edge removal"});
          if (expq.size() != 0) void'(expq.pop_front());
        end
        one_tick(rdy);
      end
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    brk = (dm == 8'h00) && !stopv && (!cfg_par_en || !pb);
    cap = cfg_buf_en ? BENCH_DEPTH : 1;
    if (expq.size() < cap) expq.push_back({dm, !stopv, cfg_par_en & flip, brk});
    else exp_ovr = 1'b1;
  endtask

  task automatic drain(input string req);
    while (expq.size() != 0) pop_one(req);
    chk({req, " empty"}, int'(chr_valid), 0);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic ev,
                         input logic st, input logic be);
    cfg_len = l; cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = st; cfg_buf_en = be;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; os_tick = 1'b0; rx_line = 1'b1; chr_ready = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 valid after reset", int'(chr_valid), 0);
    chk("R10 overrun after reset", int'(rx_overrun), 0);

    // R1: each word length, upper bits cleared
    for (int l = 0; l < 4; l++) begin
      set_cfg(2'(l), 1'b0, 1'b0, 1'b0, 1'b1);
      send(8'hB5 ^ 8'(l * 8'h11), 1'b0, 1'b1, 1'b0, "R1");
      pop_one("R1 word length");
    end

    // R2: even and odd parity, good and corrupted
    for (int k = 0; k < 4; k++) begin
      set_cfg(2'd3, 1'b1, k[0], 1'b0, 1'b1);
      send(8'h6A + 8'(k), k[1], 1'b1, 1'b0, "R2");
      pop_one("R2 parity");
    end

    // R3: stick parity independent of data
    for (int k = 0; k < 8; k++) begin
      set_cfg(2'd2, 1'b1, k[0], 1'b1, 1'b1);
      send(k[2] ? 8'h01 : 8'h03, k[1], 1'b1, 1'b0, "R3");
      pop_one("R3 stick parity");
    end

    // R5: low stop bit gives framing error
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b0, 1'b0, "R5");
    pop_one("R5 framing error");

    // R6: break with and without parity, and a near-break with parity bit high
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
    send(8'h00, 1'b0, 1'b0, 1'b0, "R6");
    pop_one("R6 break even parity");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h00, 1'b0, 1'b0, 1'b0, "R6");
    pop_one("R6 break no parity");
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    send(8'h00, 1'b0, 1'b0, 1'b0, "R6");
    pop_one("R6 parity bit high is not break");

    // R4: short low pulse is rejected
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    repeat (5) one_tick(1'b0);
    rx_line = 1'b1;
    repeat (40) one_tick(1'b0);
    chk("R4 glitch gives no character", int'(chr_valid), 0);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h5A, 1'b0, 1'b1, 1'b0, "R4");
    pop_one("R4 frame after glitch");

    // R7: frames back to back with one stop bit each
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    send(8'h81, 1'b0, 1'b1, 1'b0, "R7");
    send(8'h7E, 1'b0, 1'b1, 1'b0, "R7");
    send(8'hFF, 1'b0, 1'b1, 1'b0, "R7");
    drain("R7 single stop");

    // R8: queue fills to depth in order
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < BENCH_DEPTH; k++) send(8'h10 + 8'(k), 1'b0, 1'b1, 1'b0, "R8");
    chk("R8 full queue no overrun", int'(rx_overrun), 0);
    drain("R8 queue order");

    // random mix in queue mode
    for (int n = 0; n < 90; n++) begin
      set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
              1'($urandom % 4 == 0), 1'b1);
      send(($urandom % 8 == 0) ? 8'h00 : 8'($urandom), cfg_par_en && ($urandom % 6 == 0),
           ($urandom % 8) != 0, 1'b0, "R2 random");
      if (($urandom % 4) != 0 || expq.size() >= 3) drain("R2 random");
    end
    drain("R8 random tail");

    // R9: removal and completion on the same edge in single mode
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hA1, 1'b0, 1'b1, 1'b0, "R8");
    send(8'hB2, 1'b0, 1'b1, 1'b1, "R9");
    chk("R9 same-edge removal no overrun", int'(rx_overrun), 0);
    pop_one("R9 new character kept");
    // R8, R9: single holding place overflows
    send(8'hC3, 1'b0, 1'b1, 1'b0, "R9");
    send(8'hD4, 1'b0, 1'b1, 1'b0, "R9");
    chk("R9 overrun set", int'(rx_overrun), int'(exp_ovr));
    pop_one("R9 held character survives drop");
    chk("R8 single mode holds one", int'(chr_valid), 0);
    repeat (10) @(negedge clk);
    chk("R9 overrun sticky", int'(rx_overrun), 1);

    summary();
    $finish;
  end

endmodule